// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block finds a translation entry in a hashed page table that sits in memory. A request gives it a hash value, an abbreviated virtual page tag and the page shift of the segment. It also gives the table base and the table mask, and the block holds all of these while it works. The searcher reads the eight entries of the primary group one at a time through a single read port. If none of them matches, it reads the eight entries of the secondary group, which is selected by the complemented hash.

Each entry is two 64-bit doublewords. An entry matches when all four checks pass: the valid bit, the secondary-hash flag, the tag and the page-size encoding against the segment's page shift. The result comes back as a one-cycle done pulse. The pulse carries a hit flag, the byte address of the matching entry and both of its doublewords. When neither group holds a match, the pulse carries a miss.

Top module: `hpt_group_search`

## Requirements
- R1: An entry can match only when bit 0 of its first doubleword (valid) is 1.
- R2: Bit 1 of the first doubleword (secondary flag) must be 0 for a match in the primary pass and 1 for a match in the secondary pass.
- R3: Bits 63:7 of the first doubleword must equal the request tag `vtag`.
- R4: With page shift 12, an entry that passes R1 to R3 matches regardless of the second doubleword.
- R5: With page shift 16, an entry matches only if bits 15:12 of the second doubleword are 4'b0001 and parameter EN_64K is 1. With EN_64K at 0, page shift 16 never matches.
- R6: With page shift 24, an entry matches only if bits 19:12 of the second doubleword are all zero.
- R7: Any other page shift never matches. An entry that fails any check does not end the search. The first matching entry in read order is the one reported.
- R8: Entry i of a group (i = 0 to 7) is read at byte address (base | (sel << 7)) + 16*i, in ascending i. In the primary pass sel is hash & mask. In the secondary pass sel is ~hash & mask. The secondary pass runs only after all eight primary entries miss.
- R9: A search that misses both groups reports hit 0, offset all ones, and both doublewords zero.
- R10: `done` is high for exactly one cycle per accepted request. `start` is accepted only while `busy` is low, and a `start` while busy has no effect on the result.
- R11: `mem_rd_valid` and `mem_rd_addr` stay unchanged until `mem_rd_ready` is seen. No new read is issued before the response to the previous read has arrived.
- R12: After reset, `busy`, `done` and `mem_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| hash | input | HASH_W | Primary hash value |
| vtag | input | 57 | Abbreviated virtual page tag |
| pshift | input | 5 | Segment page shift |
| tbl_base | input | AW | Table base address |
| tbl_mask | input | HASH_W | Table hash mask |
| busy | output | 1 | Search in progress |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | AW | Byte address of entry being read |
| mem_resp_valid | input | 1 | Read response valid |
| mem_resp_dw0 | input | 64 | First doubleword of entry |
| mem_resp_dw1 | input | 64 | Second doubleword of entry |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Match found |
| offset | output | AW | Matching entry address, all ones on miss |
| dw0 | output | 64 | First doubleword of match |
| dw1 | output | 64 | Second doubleword of match |

## Verification
The assertions rely on two assumptions about the memory side. First, a response arrives only while a read is outstanding. Second, a response is a single beat that carries both doublewords. The bench's memory model follows both rules: it answers every accepted read exactly once, one cycle after acceptance, and it never answers at any other time. The model also varies its ready signal to exercise request hold. The results are compared with a software search of the same table contents across every hash, several page shifts and two base/mask settings.

// File: rtl/hpt_group_search.sv
module hpt_group_search #(
  parameter int AW      = 48,
  parameter int HASH_W  = 20,
  parameter int ENTRIES = 8,
  parameter bit EN_64K  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HASH_W-1:0] hash,
  input  logic [63:7]       vtag,
  input  logic [4:0]        pshift,
  input  logic [AW-1:0]     tbl_base,
  input  logic [HASH_W-1:0] tbl_mask,
  output logic              busy,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_resp_valid,
  input  logic [63:0]       mem_resp_dw0,
  input  logic [63:0]       mem_resp_dw1,
  output logic              done,
  output logic              hit,
  output logic [AW-1:0]     offset,
  output logic [63:0]       dw0,
  output logic [63:0]       dw1
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int GRP_SH = IDX_W + 4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [HASH_W-1:0] hash_q, mask_q;
  logic [63:7]       tag_q;
  logic [4:0]        psh_q;
  logic [AW-1:0]     base_q;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic              size_ok;

  wire [HASH_W-1:0] grp_sel  = (pass_q ? ~hash_q : hash_q) & mask_q;
  wire [AW-1:0]     grp_addr = base_q | (AW'(grp_sel) << GRP_SH);
  assign mem_rd_addr  = grp_addr + (AW'(idx_q) << 4);
  assign mem_rd_valid = (st == S_REQ);
  assign busy         = (st != S_IDLE);

  always_comb begin
    case (psh_q)
      5'd12:   size_ok = 1'b1;
      5'd16:   size_ok = EN_64K && (mem_resp_dw1[15:12] == 4'b0001);
      5'd24:   size_ok = (mem_resp_dw1[19:12] == 8'h00);
      default: size_ok = 1'b0;
    endcase
  end

  wire ent_hit = mem_resp_dw0[0] && (mem_resp_dw0[1] == pass_q)
               && (mem_resp_dw0[63:7] == tag_q) && size_ok;
  wire last    = (idx_q == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hash_q <= '0;
      mask_q <= '0;
      tag_q  <= '0;
      psh_q  <= '0;
      base_q <= '0;
      pass_q <= 1'b0;
      idx_q  <= '0;
      done   <= 1'b0;
      hit    <= 1'b0;
      offset <= '0;
      dw0    <= '0;
      dw1    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          hash_q <= hash;
          mask_q <= tbl_mask;
          tag_q  <= vtag;
          psh_q  <= pshift;
          base_q <= tbl_base;
          pass_q <= 1'b0;
          idx_q  <= '0;
          st     <= S_REQ;
        end
        S_REQ: if (mem_rd_ready) st <= S_WAIT;
        S_WAIT: if (mem_resp_valid) begin
          if (ent_hit) begin
            done   <= 1'b1;
            hit    <= 1'b1;
            offset <= mem_rd_addr;
            dw0    <= mem_resp_dw0;
            dw1    <= mem_resp_dw1;
            st     <= S_IDLE;
          end else if (!last) begin
            idx_q <= idx_q + 1'b1;
            st    <= S_REQ;
          end else if (!pass_q) begin
            pass_q <= 1'b1;
            idx_q  <= '0;
            st     <= S_REQ;
          end else begin
            done   <= 1'b1;
            hit    <= 1'b0;
            offset <= '1;
            dw0    <= '0;
            dw1    <= '0;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);
  a_r9_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hit |-> (offset == '1) && (dw0 == 64'd0) && (dw1 == 64'd0));
  a_r1_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit |-> dw0[0]);
  a_r5_no_64k: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit |-> (EN_64K || psh_q != 5'd16));
  a_r7_known_size: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit |-> (psh_q == 5'd12 || psh_q == 5'd16 || psh_q == 5'd24));
endmodule

// File: tb/hpt_group_search_tb_top.sv
module hpt_group_search_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  hash = '0, tbl_mask = '0;
  logic [63:7] vtag = '0;
  logic [4:0]  pshift = '0;
  logic [15:0] tbl_base = '0;

  logic [63:0] m0 [0:127];
  logic [63:0] m1 [0:127];

  logic a_busy, a_rv, a_done, a_hit;
  logic [15:0] a_addr, a_off;
  logic [63:0] a_d0, a_d1;
  logic a_rdy = 1'b0, a_respv = 1'b0;
  logic [63:0] a_r0 = '0, a_r1 = '0;
  logic b_busy, b_rv, b_done, b_hit;
  logic [15:0] b_addr, b_off;
  logic [63:0] b_d0, b_d1;
  logic b_rdy = 1'b1, b_respv = 1'b0;
  logic [63:0] b_r0 = '0, b_r1 = '0;

  hpt_group_search #(.AW(16), .HASH_W(3), .ENTRIES(8), .EN_64K(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hash(hash), .vtag(vtag), .pshift(pshift),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask), .busy(a_busy),
    .mem_rd_valid(a_rv), .mem_rd_ready(a_rdy), .mem_rd_addr(a_addr),
    .mem_resp_valid(a_respv), .mem_resp_dw0(a_r0), .mem_resp_dw1(a_r1),
    .done(a_done), .hit(a_hit), .offset(a_off), .dw0(a_d0), .dw1(a_d1));

  hpt_group_search #(.AW(16), .HASH_W(3), .ENTRIES(8), .EN_64K(1'b0)) dut_no64k_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hash(hash), .vtag(vtag), .pshift(pshift),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask), .busy(b_busy),
    .mem_rd_valid(b_rv), .mem_rd_ready(b_rdy), .mem_rd_addr(b_addr),
    .mem_resp_valid(b_respv), .mem_resp_dw0(b_r0), .mem_resp_dw1(b_r1),
    .done(b_done), .hit(b_hit), .offset(b_off), .dw0(b_d0), .dw1(b_d1));

  int tests = 0, fails = 0;
  int a_cnt = 0, b_cnt = 0;
  bit a_pend = 0, b_pend = 0;
  logic [15:0] a_pa = '0, b_pa = '0;
  bit finished = 0;

  always @(negedge clk) begin
    a_respv = 1'b0;
    if (a_pend) begin a_respv = 1'b1; a_r0 = m0[a_pa[10:4]]; a_r1 = m1[a_pa[10:4]]; a_pend = 0; end
    a_rdy = ($urandom % 4) != 0;
    if (a_rv && a_rdy) begin a_pend = 1; a_pa = a_addr; a_cnt++; end
  end

  always @(negedge clk) begin
    b_respv = 1'b0;
    if (b_pend) begin b_respv = 1'b1; b_r0 = m0[b_pa[10:4]]; b_r1 = m1[b_pa[10:4]]; b_pend = 0; end
    if (b_rv && b_rdy) begin b_pend = 1; b_pa = b_addr; b_cnt++; end
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] ent0(input logic [63:7] tg, input bit sec, input bit v);
    return {tg, 5'b0, sec, v};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) begin m0[i] = '0; m1[i] = '0; end
  endtask

  function automatic void ref_search(input logic [2:0] h, input logic [63:7] tg, input logic [4:0] ps,
      input logic [15:0] base, input logic [2:0] mask, input bit en64,
      output bit rh, output logic [15:0] ro, output logic [63:0] r0, output logic [63:0] r1, output int nrd);
    rh = 0; ro = '1; r0 = '0; r1 = '0; nrd = 0;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 8; i++) begin
        if (!rh) begin
          logic [2:0] gs;
          logic [15:0] ad;
          logic [63:0] e0, e1;
          bit sz;
          gs = (p == 1 ? ~h : h) & mask;
          ad = (base | (16'(gs) << 7)) + 16'(i) * 16'd16;
          e0 = m0[ad[10:4]];
          e1 = m1[ad[10:4]];
          nrd++;
          case (ps)
            5'd12:   sz = 1;
            5'd16:   sz = en64 && (e1[15:12] == 4'b0001);
            5'd24:   sz = (e1[19:12] == 8'h00);
            default: sz = 0;
          endcase
          if (e0[0] && (e0[1] == (p == 1)) && (e0[63:7] == tg) && sz) begin
            rh = 1; ro = ad; r0 = e0; r1 = e1;
          end
        end
      end
      if (rh) break;
    end
  endfunction

  bit          xa_h, xb_h;
  logic [15:0] xa_o, xb_o;
  logic [63:0] xa_0, xa_1, xb_0, xb_1;
  int          xa_n, xb_n;
  bit          ga_h, gb_h;
  logic [15:0] ga_o, gb_o;
  logic [63:0] ga_0, ga_1, gb_0, gb_1;
  int          ga_n, gb_n;

  task automatic lookup(input logic [2:0] h, input logic [63:7] tg, input logic [4:0] ps,
                        input logic [15:0] base, input logic [2:0] mask, input bit busy_poke);
    int a0, b0, guard;
    bit got_a, got_b;
    ref_search(h, tg, ps, base, mask, 1'b1, xa_h, xa_o, xa_0, xa_1, xa_n);
    ref_search(h, tg, ps, base, mask, 1'b0, xb_h, xb_o, xb_0, xb_1, xb_n);
    @(negedge clk);
    a0 = a_cnt; b0 = b_cnt;
    hash = h; vtag = tg; pshift = ps; tbl_base = base; tbl_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(a_busy && b_busy, "R10 busy after start", {63'd0, a_busy}, 64'd1);
    if (busy_poke) begin
      hash = ~h; vtag = tg ^ 57'h1; pshift = 5'd12; tbl_base = 16'h0400; start = 1'b1;
    end
    got_a = 0; got_b = 0; guard = 0;
    while (!(got_a && got_b) && guard < 500) begin
      if (a_done && !got_a) begin got_a = 1; ga_h = a_hit; ga_o = a_off; ga_0 = a_d0; ga_1 = a_d1; ga_n = a_cnt - a0; end
      if (b_done && !got_b) begin got_b = 1; gb_h = b_hit; gb_o = b_off; gb_0 = b_d0; gb_1 = b_d1; gb_n = b_cnt - b0; end
      @(negedge clk);
      start = 1'b0;
      guard++;
    end
    check(got_a && got_b, "R10 done seen", {62'd0, got_a, got_b}, 64'd3);
    check(ga_h == xa_h, "R1 R2 R3 R7 hit", {63'd0, ga_h}, {63'd0, xa_h});
    check(gb_h == xb_h, "R5 R7 hit no64k", {63'd0, gb_h}, {63'd0, xb_h});
    check(ga_o == xa_o, "R8 R9 offset", {48'd0, ga_o}, {48'd0, xa_o});
    check(gb_o == xb_o, "R8 R9 offset no64k", {48'd0, gb_o}, {48'd0, xb_o});
    check(ga_0 == xa_0 && ga_1 == xa_1, "R4 R5 R6 R9 data", ga_1, xa_1);
    check(gb_0 == xb_0 && gb_1 == xb_1, "R9 data no64k", gb_1, xb_1);
    check(ga_n == xa_n, "R8 R11 read count", 64'(ga_n), 64'(xa_n));
    check(gb_n == xb_n, "R8 R11 read count no64k", 64'(gb_n), 64'(xb_n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:7] t0;
    t0 = 57'h0_1234_5678_9ABC;
    clear_mem();
    repeat (3) @(negedge clk);
    check(!a_busy && !a_done && !a_rv && !b_busy && !b_done && !b_rv, "R12 reset state",
          {61'd0, a_busy, a_done, a_rv}, 64'd0);
    rst_n = 1'b1;

    // R1 R3 R7: idx0 invalid, idx1 wrong tag, idx2 and idx5 match -> idx2
    clear_mem();
    m0[40] = ent0(t0, 0, 0);
    m0[41] = ent0(t0 ^ 57'h4, 0, 1);
    m0[42] = ent0(t0, 0, 1); m1[42] = 64'hAAAA_0000_0000_5000;
    m0[45] = ent0(t0, 0, 1);
    lookup(3'd5, t0, 5'd12, 16'h0000, 3'd7, 0);
    check(ga_h && ga_o == 16'h02A0 && ga_n == 3, "R1 R3 R7 first match", {48'd0, ga_o}, 64'h02A0);
    check(ga_1 == 64'hAAAA_0000_0000_5000, "R4 size ignored", ga_1, 64'hAAAA_0000_0000_5000);

    // R2 R8: primary entries carry secondary flag; secondary group 2 idx1 matches
    clear_mem();
    for (int i = 0; i < 8; i++) m0[40 + i] = ent0(t0, 1, 1);
    m0[16] = ent0(t0, 0, 1);
    m0[17] = ent0(t0, 1, 1);
    lookup(3'd5, t0, 5'd12, 16'h0000, 3'd7, 0);
    check(ga_h && ga_o == 16'h0110 && ga_n == 10, "R2 R8 secondary pass", {48'd0, ga_o}, 64'h0110);

    // R5: 64K encoding, hit only with option on
    clear_mem();
    m0[40] = ent0(t0, 0, 1); m1[40] = 64'h0000_0000_0000_1000;
    lookup(3'd5, t0, 5'd16, 16'h0000, 3'd7, 0);
    check(ga_h && ga_o == 16'h0280, "R5 64K hit", {48'd0, ga_o}, 64'h0280);
    check(!gb_h && gb_o == 16'hFFFF && gb_n == 16, "R5 R9 64K disabled miss", {48'd0, gb_o}, 64'hFFFF);

    // R6: 16M needs bits 19:12 clear
    m0[43] = ent0(t0, 0, 1); m1[43] = 64'h0000_0000_0000_1000;
    m0[44] = ent0(t0, 0, 1); m1[44] = 64'h0000_0000_0010_0FFF;
    lookup(3'd5, t0, 5'd24, 16'h0000, 3'd7, 0);
    check(ga_h && ga_o == 16'h02C0, "R6 16M match", {48'd0, ga_o}, 64'h02C0);

    // R7 R9: unsupported shift never matches
    lookup(3'd5, t0, 5'd20, 16'h0000, 3'd7, 0);
    check(!ga_h && ga_o == 16'hFFFF && ga_0 == 0, "R7 R9 bad shift miss", {48'd0, ga_o}, 64'hFFFF);

    // R10: start while busy is ignored, no extra done afterwards
    lookup(3'd5, t0, 5'd24, 16'h0000, 3'd7, 1);
    check(ga_h && ga_o == 16'h02C0, "R10 busy start ignored", {48'd0, ga_o}, 64'h02C0);
    begin
      bit extra;
      extra = 0;
      repeat (6) begin @(negedge clk); if (a_done || b_done || a_busy) extra = 1; end
      check(!extra, "R10 no second result", {63'd0, extra}, 64'd0);
    end

    // sweep: random tables, every hash, several shifts, two base/mask settings
    for (int r = 0; r < 10; r++) begin
      logic [15:0] bs;
      logic [2:0]  mk;
      bs = (r % 2 == 1) ? 16'h0400 : 16'h0000;
      mk = (r % 2 == 1) ? 3'd3 : 3'd7;
      for (int i = 0; i < 128; i++) begin
        logic [63:7] tg;
        logic [63:0] sz;
        case ($urandom % 3) 0: tg = t0; 1: tg = t0 ^ 57'h1; default: tg = t0 ^ (57'h1 << 40); endcase
        case ($urandom % 5)
          0: sz = 64'h0; 1: sz = 64'h1000; 2: sz = 64'h2000; 3: sz = 64'h11000; default: sz = 64'h80000;
        endcase
        m0[i] = ent0(tg, ($urandom % 2) == 1, ($urandom % 3) != 0);
        m1[i] = ({$urandom, $urandom} & ~64'hFF000) | sz;
      end
      for (int h = 0; h < 8; h++) begin
        for (int k = 0; k < 4; k++) begin
          logic [4:0] ps;
          case (k) 0: ps = 5'd12; 1: ps = 5'd16; 2: ps = 5'd24; default: ps = 5'd20; endcase
          lookup(3'(h), (k % 2 == 1) ? (t0 ^ 57'h1) : t0, ps, bs, mk, 0);
        end
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule